// File: doc/BRIEF.md
# Global Register Command Decoder

This block sits behind the byte-level receive side of a microprocessor control port. It watches a stream of bytes that arrive with a valid strobe and a frame-start marker, and acts on a small set of chip-wide registers. A frame begins with a command byte. Bit 7 of that byte gives the direction: 0 for a read, 1 for a write. A read is answered one cycle later with a response byte. A write uses the next byte of the same frame as its data byte.

Several write commands carry no register at all. Instead they produce one-cycle action pulses, which the local register banks and the line-interface logic use: interrupt clear, a software reset of local state, and a hardware-reset request. These pulses fire only when the data byte that follows is all ones, so a corrupted frame cannot trigger them by accident. The block also holds the chopper-clock selection register. That register has two select fields, one for the fast clock output and one for the slow clock output. A hardware-reset request returns it to 00h. A software reset leaves it unchanged.

Top module: `gcmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, all pulses and `rsp_valid` are low, `rsp_byte` is 00h and both chopper select outputs are 0.
- R2: A byte with `rx_valid` and `frame_start` both high is a command. If bit 7 of the command is 1, the next valid byte without `frame_start` is its data byte. Any further bytes before the next `frame_start`, and any byte that arrives outside a frame, are ignored.
- R3: A read of address 20h (command byte 20h) produces `rsp_valid` high for one cycle, in the cycle after the command byte, with `rsp_byte` = 01h.
- R4: A read of 24h returns the chopper register: bits [5:4] are the fast-clock select, bits [3:0] are the slow-clock select, and bits [7:6] read 0.
- R5: A read of any other address returns 00h. A write with an unknown command code changes no output.
- R6: A write with command A4h stores data bits [5:4] into `chop_fast_sel` and data bits [3:0] into `chop_slow_sel`. Data bits [7:6] are discarded. The outputs update in the cycle after the data byte.
- R7: Command A1h, A2h or A3h followed by data FFh raises `irq_clear_pulse`, `local_reset_pulse` or `hw_reset_pulse` respectively, for the cycle after the data byte.
- R8: If the data byte after A1h, A2h or A3h is not FFh, the command is discarded and no pulse is issued.
- R9: Command A0h is a no-operation: with any data byte it produces no pulse, no response and no register change.
- R10: The software-reset command (A2h with FFh) leaves the chopper register unchanged.
- R11: The hardware-reset command (A3h with FFh) returns the chopper register to 00h in the same cycle as its pulse.
- R12: Every action pulse lasts exactly one cycle, and at most one action pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| frame_start | input | 1 | The valid byte is the first byte (command) of a frame |
| rsp_byte | output | 8 | Read response byte |
| rsp_valid | output | 1 | `rsp_byte` is valid this cycle |
| irq_clear_pulse | output | 1 | One-cycle interrupt-clear request |
| local_reset_pulse | output | 1 | One-cycle reset of the local register banks |
| hw_reset_pulse | output | 1 | One-cycle hardware-reset request |
| chop_fast_sel | output | 2 | Fast chopper clock select field |
| chop_slow_sel | output | 4 | Slow chopper clock select field |

## Verification
The bench builds the block with its default parameters: version 01h, a 2-bit fast select field and a 4-bit slow select field. These values make the full register width visible through reads, so the reserved-bit masking and the field split can be seen at the ports. The command stream mixes valid and corrupted action frames, stray bytes outside frames, extra bytes after a data byte, and reads of known and unknown addresses. This shows that only the all-ones data byte fires a pulse, and that a software reset and a hardware reset treat the chopper register differently.

// File: rtl/gcmd_pkg.sv
// Package: command codes, field widths and parser state shared by the decoder.
// Assumes byte-wide commands with the direction flag in bit 7.
package gcmd_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CMD_NOP       = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_IRQ_CLR   = 8'hA1;
    localparam logic [BYTE_W-1:0] CMD_SOFT_RST  = 8'hA2;
    localparam logic [BYTE_W-1:0] CMD_HARD_RST  = 8'hA3;
    localparam logic [BYTE_W-1:0] CMD_CHOP_WR   = 8'hA4;
    localparam logic [BYTE_W-2:0] ADDR_VERSION  = 7'h20;
    localparam logic [BYTE_W-2:0] ADDR_CHOP     = 7'h24;
    localparam logic [BYTE_W-1:0] FILL_BYTE     = 8'hFF;
    localparam int NUM_ACT    = 3;
    localparam int ACT_IRQ    = 0;
    localparam int ACT_SOFT   = 1;
    localparam int ACT_HARD   = 2;

    typedef enum logic {
        PS_IDLE,
        PS_WAIT_DATA
    } parse_state_t;
endpackage

// File: rtl/gcmd_frame_parser.sv
// Frame parser: picks out command bytes on frame_start. Read commands are
// passed on at once. A write command is held until its data byte arrives,
// and every later byte of the frame is dropped.
// Assumes frame_start is only meaningful together with rx_valid.
module gcmd_frame_parser
    import gcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              frame_start,
    output logic              rd_req,
    output logic [BYTE_W-2:0] rd_addr,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_cmd,
    output logic [BYTE_W-1:0] wr_data
);
    parse_state_t      state_q;
    logic [BYTE_W-1:0] cmd_q;

    // Tracks whether a write command is waiting for its data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cmd_q   <= '0;
        end else if (rx_valid) begin
            if (frame_start && rx_byte[BYTE_W-1]) begin
                state_q <= PS_WAIT_DATA;
                cmd_q   <= rx_byte;
            end else begin
                state_q <= PS_IDLE;
            end
        end
    end

    // Presents read requests and completed write (command, data) pairs.
    always_comb begin
        rd_req  = rx_valid && frame_start && !rx_byte[BYTE_W-1];
        rd_addr = rx_byte[BYTE_W-2:0];
        wr_stb  = rx_valid && !frame_start && (state_q == PS_WAIT_DATA);
        wr_cmd  = cmd_q;
        wr_data = rx_byte;
    end
endmodule

// File: rtl/gcmd_action_unit.sv
// Action unit: turns action commands that are confirmed by an all-ones data
// byte into registered one-cycle pulses. It also gives the combinational
// "fire" vector to the register that the hardware reset clears.
// Assumes wr_stb is high for one cycle per data byte.
module gcmd_action_unit
    import gcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [BYTE_W-1:0]  wr_cmd,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [NUM_ACT-1:0] act_fire,
    output logic [NUM_ACT-1:0] act_pulse
);
    logic confirmed;

    // A data byte confirms an action only when it is all ones.
    always_comb confirmed = wr_stb && (wr_data == FILL_BYTE);

    for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
        localparam logic [BYTE_W-1:0] CODE = CMD_IRQ_CLR + BYTE_W'(i);

        // Decodes one action code.
        always_comb act_fire[i] = confirmed && (wr_cmd == CODE);

        // Registers the action as a single-cycle pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) act_pulse[i] <= 1'b0;
            else        act_pulse[i] <= act_fire[i];
        end
    end
endmodule

// File: rtl/gcmd_chop_reg.sv
// Chopper-clock selection register: written by the chopper-write command,
// returned to zero by a hardware-reset request, and left as it is by a
// software reset. Reserved bits are never stored.
module gcmd_chop_reg
    import gcmd_pkg::*;
#(
    parameter int FAST_W = 2,
    parameter int SLOW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              hw_clear,
    output logic [FAST_W-1:0] fast_sel,
    output logic [SLOW_W-1:0] slow_sel
);
    localparam int FIELD_W = FAST_W + SLOW_W;

    logic [FIELD_W-1:0] reg_q;

    // Holds the select fields; a hardware clear wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_q <= '0;
        else if (hw_clear) reg_q <= '0;
        else if (wr_en)    reg_q <= wr_data[FIELD_W-1:0];
    end

    // Splits the register into its two select fields.
    always_comb begin
        fast_sel = reg_q[FIELD_W-1:SLOW_W];
        slow_sel = reg_q[SLOW_W-1:0];
    end
endmodule

// File: rtl/gcmd_read_port.sv
// Read port: registers the response to a read command. Known addresses
// return the version constant or the chopper register; any other address
// returns zero. Reserved bits above the register fields read as zero.
module gcmd_read_port
    import gcmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VERSION_ID = 8'h01,
    parameter int                FAST_W     = 2,
    parameter int                SLOW_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [BYTE_W-2:0] rd_addr,
    input  logic [FAST_W-1:0] fast_sel,
    input  logic [SLOW_W-1:0] slow_sel,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);
    localparam int PAD_W = BYTE_W - FAST_W - SLOW_W;

    logic [BYTE_W-1:0] lookup;

    // Selects the register image for the requested address.
    always_comb begin
        unique case (rd_addr)
            ADDR_VERSION: lookup = VERSION_ID;
            ADDR_CHOP:    lookup = {{PAD_W{1'b0}}, fast_sel, slow_sel};
            default:      lookup = '0;
        endcase
    end

    // Registers the response for one cycle and keeps the bus at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_byte  <= rd_req ? lookup : '0;
        end
    end
endmodule

// File: rtl/gcmd_decoder.sv
// Top level: connects the frame parser, the action unit, the chopper
// register and the read port. Synchronous active-low reset throughout.
// Assumes byte framing (valid plus frame start) is done upstream.
module gcmd_decoder
    import gcmd_pkg::*;
#(
    parameter logic [7:0] VERSION_ID = 8'h01,
    parameter int         FAST_W     = 2,
    parameter int         SLOW_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              frame_start,
    output logic [7:0]        rsp_byte,
    output logic              rsp_valid,
    output logic              irq_clear_pulse,
    output logic              local_reset_pulse,
    output logic              hw_reset_pulse,
    output logic [FAST_W-1:0] chop_fast_sel,
    output logic [SLOW_W-1:0] chop_slow_sel
);
    logic               rd_req;
    logic [BYTE_W-2:0]  rd_addr;
    logic               wr_stb;
    logic [BYTE_W-1:0]  wr_cmd;
    logic [BYTE_W-1:0]  wr_data;
    logic [NUM_ACT-1:0] act_fire;
    logic [NUM_ACT-1:0] act_pulse;
    logic               chop_wr;

    gcmd_frame_parser u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .frame_start (frame_start),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .wr_stb      (wr_stb),
        .wr_cmd      (wr_cmd),
        .wr_data     (wr_data)
    );

    gcmd_action_unit u_actions (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .act_fire  (act_fire),
        .act_pulse (act_pulse)
    );

    // Chopper register write enable: data byte of a chopper-write command.
    always_comb chop_wr = wr_stb && (wr_cmd == CMD_CHOP_WR);

    gcmd_chop_reg #(
        .FAST_W (FAST_W),
        .SLOW_W (SLOW_W)
    ) u_chop (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (chop_wr),
        .wr_data  (wr_data),
        .hw_clear (act_fire[ACT_HARD]),
        .fast_sel (chop_fast_sel),
        .slow_sel (chop_slow_sel)
    );

    gcmd_read_port #(
        .VERSION_ID (VERSION_ID),
        .FAST_W     (FAST_W),
        .SLOW_W     (SLOW_W)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .fast_sel  (chop_fast_sel),
        .slow_sel  (chop_slow_sel),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );

    // Maps the action vector onto the named pulse ports.
    always_comb begin
        irq_clear_pulse   = act_pulse[ACT_IRQ];
        local_reset_pulse = act_pulse[ACT_SOFT];
        hw_reset_pulse    = act_pulse[ACT_HARD];
    end
endmodule

// File: rtl/gcmd_decoder_chk.sv
// Checker for gcmd_decoder: port-level timing properties, attached by bind.
module gcmd_decoder_chk #(
    parameter int FAST_W = 2,
    parameter int SLOW_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rx_byte,
    input logic              rx_valid,
    input logic              frame_start,
    input logic [7:0]        rsp_byte,
    input logic              rsp_valid,
    input logic              irq_clear_pulse,
    input logic              local_reset_pulse,
    input logic              hw_reset_pulse,
    input logic [FAST_W-1:0] chop_fast_sel,
    input logic [SLOW_W-1:0] chop_slow_sel
);
    // R3: a response follows a read command byte one cycle earlier
    a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rx_valid && frame_start && !rx_byte[7]));

    // R8: a pulse requires an all-ones data byte in the previous cycle
    a_r8_pulse_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear_pulse || local_reset_pulse || hw_reset_pulse) |->
        $past(rx_valid && !frame_start && rx_byte == 8'hFF));

    // R12: pulses last one cycle and never overlap
    a_r12_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear_pulse |=> !irq_clear_pulse);
    a_r12_soft_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        local_reset_pulse |=> !local_reset_pulse);
    a_r12_hard_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_pulse |=> !hw_reset_pulse);
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_clear_pulse, local_reset_pulse, hw_reset_pulse}));

    // R11: the hardware-reset pulse coincides with a cleared chopper register
    a_r11_hw_clears_chop: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_pulse |-> (chop_fast_sel == '0 && chop_slow_sel == '0));

    // R6: chopper fields change only after a non-command byte
    a_r6_chop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid && !frame_start) |->
        ($stable(chop_fast_sel) && $stable(chop_slow_sel)));

    // R4: reserved response bits stay clear for a chopper read
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rx_byte == 8'h24)) |-> (rsp_byte[7:6] == 2'b00));
endmodule

bind gcmd_decoder gcmd_decoder_chk #(
    .FAST_W (FAST_W),
    .SLOW_W (SLOW_W)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .rx_byte           (rx_byte),
    .rx_valid          (rx_valid),
    .frame_start       (frame_start),
    .rsp_byte          (rsp_byte),
    .rsp_valid         (rsp_valid),
    .irq_clear_pulse   (irq_clear_pulse),
    .local_reset_pulse (local_reset_pulse),
    .hw_reset_pulse    (hw_reset_pulse),
    .chop_fast_sel     (chop_fast_sel),
    .chop_slow_sel     (chop_slow_sel)
);

// File: tb/gcmd_decoder_tb_top.sv
// Scoreboard bench: the driver pushes expected output events, and a monitor
// on the falling edge pops and compares every event the design produces.
module gcmd_decoder_tb_top;
    typedef struct {
        int         kind;   // 1 response, 2 irq clear, 3 local reset, 4 hw reset
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] rsp_byte;
    logic       rsp_valid;
    logic       irq_clear_pulse, local_reset_pulse, hw_reset_pulse;
    logic [1:0] chop_fast_sel;
    logic [3:0] chop_slow_sel;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];
    logic [5:0] chop_model = 6'h00;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    gcmd_decoder dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .rx_byte           (rx_byte),
        .rx_valid          (rx_valid),
        .frame_start       (frame_start),
        .rsp_byte          (rsp_byte),
        .rsp_valid         (rsp_valid),
        .irq_clear_pulse   (irq_clear_pulse),
        .local_reset_pulse (local_reset_pulse),
        .hw_reset_pulse    (hw_reset_pulse),
        .chop_fast_sel     (chop_fast_sel),
        .chop_slow_sel     (chop_slow_sel)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sends one byte for a single cycle, followed by an idle cycle.
    task automatic send(input logic [7:0] b, input bit fs);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1; frame_start = fs;
        @(negedge clk);
        rx_valid = 1'b0; frame_start = 1'b0; rx_byte = 8'h00;
    endtask

    task automatic rd(input logic [7:0] addr, input logic [7:0] expv, input string req);
        exp_q.push_back('{1, expv, req});
        send(addr, 1'b1);
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] data, input string req);
        if (data == 8'hFF && cmd inside {8'hA1, 8'hA2, 8'hA3})
            exp_q.push_back('{int'(cmd - 8'hA1) + 2, 8'h00, req});
        if (cmd == 8'hA4) chop_model = data[5:0];
        if (cmd == 8'hA3 && data == 8'hFF) chop_model = 6'h00;
        send(cmd, 1'b1);
        send(data, 1'b0);
    endtask

    task automatic check_chop(input string req);
        @(negedge clk);
        check(req, {10'd0, chop_fast_sel, chop_slow_sel}, {10'd0, chop_model});
    endtask

    // Monitor: every output event must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int k;
            k = 0;
            if (rsp_valid) k = 1;
            if (irq_clear_pulse) k = 2;
            if (local_reset_pulse) k = 3;
            if (hw_reset_pulse) k = 4;
            if (int'(irq_clear_pulse) + int'(local_reset_pulse) + int'(hw_reset_pulse)
                + int'(rsp_valid) > 1)
                check("R12 overlap", 16'd1, 16'd0);
            if (k != 0) begin
                if (exp_q.size() == 0) begin
                    check("R5/R8/R9 unexpected event", 16'(k), 16'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.req, {8'(k), (k == 1) ? rsp_byte : 8'h00}, {8'(e.kind), e.val});
                end
            end
        end
    end

    initial begin
        #200000;
        $display("FAIL watchdog actual=running expected=done");
        n_fail++; n_tests++;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs",
              {rsp_byte, rsp_valid, irq_clear_pulse, local_reset_pulse, hw_reset_pulse, 4'd0},
              16'h0000);
        check("R1 reset chop", {10'd0, chop_fast_sel, chop_slow_sel}, 16'h0000);
        rst_n = 1'b1;

        rd(8'h20, 8'h01, "R3 version read");
        rd(8'h24, 8'h00, "R4 chop read default");
        wr(8'hA4, 8'hF9, "R6");
        check_chop("R6 chop write masks reserved");
        rd(8'h24, 8'h39, "R4 chop read after write");
        rd(8'h31, 8'h00, "R5 unknown read");
        wr(8'hB7, 8'hFF, "R5");
        check_chop("R5 unknown write no change");
        wr(8'hA1, 8'hFF, "R7 irq clear pulse");
        wr(8'hA1, 8'hFE, "R8");
        wr(8'hA2, 8'h7F, "R8");
        wr(8'hA3, 8'h00, "R8");
        check_chop("R8 rejected hw reset keeps chop");
        wr(8'hA0, 8'hFF, "R9");
        wr(8'hA0, 8'h12, "R9");
        check_chop("R9 nop no change");
        wr(8'hA2, 8'hFF, "R7 local reset pulse");
        check_chop("R10 soft reset keeps chop");
        rd(8'h24, 8'h39, "R10 chop read after soft reset");
        // R2: a stray byte outside a frame and an extra byte after data are ignored
        send(8'hFF, 1'b0);
        send(8'hA4, 1'b1);
        send(8'h05, 1'b0);
        chop_model = 6'h05;
        send(8'hFF, 1'b0);
        check_chop("R2 framing");
        wr(8'hA4, 8'h2A, "R6");
        wr(8'hA3, 8'hFF, "R7 hw reset pulse");
        check_chop("R11 hw reset clears chop");
        rd(8'h24, 8'h00, "R11 chop read after hw reset");
        // R12: back-to-back actions still give separate single pulses
        wr(8'hA1, 8'hFF, "R12 first pulse");
        wr(8'hA2, 8'hFF, "R12 second pulse");
        repeat (4) @(negedge clk);
        check("R12 scoreboard drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule